// File: doc/BRIEF.md
# Waveform Sampler with Single-Pole Low-Pass

This block sits behind the voltage-channel converter. Each new 16-bit signed sample, marked by a strobe, moves a first-order low-pass filter one step. The filter keeps guard bits below the sample's least significant bit. Its pole sits near 140 Hz at the assumed sample rate of about 28 kHz, so a 60 Hz tone loses roughly 0.7 dB.

The filtered value is cut back to 16 bits and sign-extended to a 24-bit waveform word. The word is written only when waveform capture is enabled and the 2-bit source field selects the voltage channel. The filter still advances on every strobe, so it stays settled while another source is shown. A one-cycle ready flag marks each new word.

Top module: `wave_sampler`

## Requirements
- R1: While reset (active low) is asserted and right after it, `waveOut` is 0 and `waveReady` is 0.
- R2: A strobe sampled at a clock edge with `sampleEn`=1 and `srcSel`=2'b11 makes `waveOut` show the new filter output right after that same edge.
- R3: A strobe with `srcSel` of 2'b00, 2'b01 or 2'b10, or with `sampleEn`=0, leaves `waveOut` unchanged and raises no `waveReady`.
- R4: `waveReady` is high for exactly the one clock cycle that follows each register update, and is low at all other times.
- R5: The filter state S is 24 bits wide, with 8 guard bits. On every strobe with input x, S becomes S + (((x<<8) - S) >>> 5), where the shift is arithmetic and rounds toward minus infinity. The filter output is S >>> 8.
- R6: `waveOut` is the 16-bit filter output sign-extended to 24 bits, so bits 23 down to 15 are all equal.
- R7: A constant input held for 400 strobes settles the output to within one LSB of the input. This holds at the full-scale codes 0x2852 and 0xD7AE.
- R8: Each strobe moves the filter state to a value between its previous value and the scaled input. This includes strobes that do not update `waveOut`, so the next selected word reflects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | New sample valid for one cycle |
| sampleIn | input | 16 | Signed voltage sample |
| srcSel | input | 2 | Waveform source field; 2'b11 selects this channel |
| sampleEn | input | 1 | Waveform capture enable |
| waveOut | output | 24 | Filtered, sign-extended waveform word |
| waveReady | output | 1 | One-cycle flag after each word update |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8 guard bits, a shift of 5 and a 24-bit word. With these values, the full-scale codes settle within a few hundred strobes. This brings within reach the asymmetric settling of the floor shift: positive inputs stop one LSB short, while negative inputs land exactly on the input. The short shift also lets a single strobe show a visible step. That makes the hidden advance of the filter on unselected strobes observable at the next selected word.

// File: rtl/wave_sampler_pkg.sv
package wave_sampler_pkg;
  typedef struct packed {
    logic filtStep;
    logic regLoad;
  } dpCtrlT;
endpackage

// File: rtl/wave_sampler_ctrl.sv
module wave_sampler_ctrl
  import wave_sampler_pkg::*;
#(
  parameter logic [1:0] SEL_CODE = 2'b11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStrobe,
  input  logic [1:0] srcSel,
  input  logic       sampleEn,
  output dpCtrlT     dpCtrl,
  output logic       readyQ
);
  logic chanPicked;

  always_comb begin
    chanPicked     = sampleEn && (srcSel == SEL_CODE);
    dpCtrl.filtStep = sampleStrobe;
    dpCtrl.regLoad  = sampleStrobe && chanPicked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= dpCtrl.regLoad;
  end

  // R4: the ready flag can only follow a strobe
  assert_ready_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |-> $past(sampleStrobe));
endmodule

// File: rtl/wave_sampler_dp.sv
module wave_sampler_dp
  import wave_sampler_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int GUARD = 8,
  parameter int SHIFT = 5,
  parameter int OUT_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrlT                 dpCtrl,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic [OUT_W-1:0]       waveOut
);
  localparam int SW  = IN_W + GUARD;
  localparam int DW  = SW + 1;
  localparam int EXT = OUT_W - IN_W;

  logic signed [SW-1:0] filtState;
  logic signed [SW-1:0] filtTarget;
  logic signed [DW-1:0] diffVal;
  logic signed [DW-1:0] stepVal;
  logic signed [DW-1:0] sumVal;
  logic signed [SW-1:0] filtNext;
  logic [IN_W-1:0]      narrowOut;
  logic [OUT_W-1:0]     wideOut;

  always_comb begin
    filtTarget = {sampleIn, {GUARD{1'b0}}};
    diffVal    = DW'(filtTarget) - DW'(filtState);
    stepVal    = diffVal >>> SHIFT;
    sumVal     = DW'(filtState) + stepVal;
    filtNext   = sumVal[SW-1:0];
    narrowOut  = filtNext[SW-1:GUARD];
  end

  generate
    if (EXT > 0) begin : gExt
      assign wideOut = {{EXT{narrowOut[IN_W-1]}}, narrowOut};
    end else begin : gNoExt
      assign wideOut = narrowOut[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtState <= '0;
      waveOut   <= '0;
    end else begin
      if (dpCtrl.filtStep) filtState <= filtNext;
      if (dpCtrl.regLoad)  waveOut   <= wideOut;
    end
  end

  // R8: each step lands between the old state and the scaled input
  assert_step_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.filtStep |=>
      ((filtState >= $past(filtState) && filtState <= $past(filtTarget)) ||
       (filtState <= $past(filtState) && filtState >= $past(filtTarget))));
endmodule

// File: rtl/wave_sampler.sv
module wave_sampler
  import wave_sampler_pkg::*;
#(
  parameter int         IN_W     = 16,
  parameter int         GUARD    = 8,
  parameter int         SHIFT    = 5,
  parameter int         OUT_W    = 24,
  parameter logic [1:0] SEL_CODE = 2'b11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic [IN_W-1:0]  sampleIn,
  input  logic [1:0]       srcSel,
  input  logic             sampleEn,
  output logic [OUT_W-1:0] waveOut,
  output logic             waveReady
);
  dpCtrlT dpCtrl;

  wave_sampler_ctrl #(.SEL_CODE(SEL_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .srcSel(srcSel),
    .sampleEn(sampleEn), .dpCtrl(dpCtrl), .readyQ(waveReady));

  wave_sampler_dp #(.IN_W(IN_W), .GUARD(GUARD), .SHIFT(SHIFT), .OUT_W(OUT_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .sampleIn(sampleIn), .waveOut(waveOut));

  // R3: no selected strobe means the word holds
  assert_hold_unselected_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStrobe && sampleEn && srcSel == SEL_CODE) |=> $stable(waveOut));
  // R4: ready follows a selected strobe
  assert_ready_selected_R4: assert property (@(posedge clk) disable iff (!rstN)
    waveReady |-> $past(sampleEn && srcSel == SEL_CODE));
  // R6: upper bits replicate the sign
  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(waveOut[OUT_W-1:IN_W-1]) == 0) ||
    ($countones(waveOut[OUT_W-1:IN_W-1]) == OUT_W - IN_W + 1));
  // R1: output quiet in the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (waveOut == '0 && !waveReady));
endmodule

// File: tb/sim_wave_sampler.sv
module sim_wave_sampler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] sampleIn = '0;
  logic [1:0]  srcSel = 2'b11;
  logic        sampleEn = 1'b1;
  logic [23:0] waveOut;
  logic        waveReady;

  int nChecks = 0;
  int nFails = 0;
  int mState = 0;
  int lastWord = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wave_sampler u0 (.clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
    .srcSel(srcSel), .sampleEn(sampleEn), .waveOut(waveOut), .waveReady(waveReady));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wordOf(input int s);
    int o;
    o = s >>> 8;
    return o & 32'hFFFFFF;
  endfunction

  // one strobe; afterwards we sit at the negedge following the capture edge
  task automatic strobe(input int x, input logic [1:0] src, input logic en);
    @(negedge clk);
    sampleIn = x[15:0]; srcSel = src; sampleEn = en; sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    mState = mState + ((x * 256 - mState) >>> 5);
    if (en && src == 2'b11) lastWord = wordOf(mState);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(waveOut == 0, "R1 word", int'(waveOut), 0);
    chk(waveReady == 0, "R1 ready", int'(waveReady), 0);
    @(negedge clk); rstN = 1'b1;
    mState = 0; lastWord = 0;
    chk(waveOut == 0, "R1 after", int'(waveOut), 0);
  endtask

  task automatic testLoad();
    strobe(16'sh1000, 2'b11, 1'b1);
    chk(int'(waveOut) == lastWord, "R2 load", int'(waveOut), lastWord);
    chk(waveReady == 1, "R4 ready high", int'(waveReady), 1);
    @(negedge clk);
    chk(waveReady == 0, "R4 ready one cycle", int'(waveReady), 0);
    chk(int'(waveOut) == wordOf(mState), "R5 recurrence", int'(waveOut), wordOf(mState));
  endtask

  task automatic testIgnore();
    int held;
    held = int'(waveOut);
    for (int s = 0; s < 3; s++) begin
      strobe(-20000, s[1:0], 1'b1);
      chk(int'(waveOut) == held, "R3 src", int'(waveOut), held);
      chk(waveReady == 0, "R3 no ready", int'(waveReady), 0);
    end
    strobe(-20000, 2'b11, 1'b0);
    chk(int'(waveOut) == held, "R3 disabled", int'(waveOut), held);
    chk(waveReady == 0, "R3 disabled ready", int'(waveReady), 0);
    // R8: hidden steps show in the next selected word
    strobe(-20000, 2'b11, 1'b1);
    chk(int'(waveOut) == lastWord, "R8 hidden advance", int'(waveOut), lastWord);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    sampleIn = 16'h0500; srcSel = 2'b11; sampleEn = 1'b1; sampleStrobe = 1'b1;
    @(negedge clk);
    mState = mState + ((16'sh0500 * 256 - mState) >>> 5);
    chk(waveReady == 1 && int'(waveOut) == wordOf(mState), "R4 b2b first", int'(waveOut), wordOf(mState));
    @(negedge clk);
    sampleStrobe = 1'b0;
    mState = mState + ((16'sh0500 * 256 - mState) >>> 5);
    lastWord = wordOf(mState);
    chk(waveReady == 1 && int'(waveOut) == lastWord, "R4 b2b second", int'(waveOut), lastWord);
    @(negedge clk);
    chk(waveReady == 0, "R4 b2b end", int'(waveReady), 0);
  endtask

  task automatic testSettle(input int x, input string tag);
    int v;
    for (int i = 0; i < 400; i++) strobe(x, 2'b11, 1'b1);
    chk(int'(waveOut) == lastWord, {tag, " model"}, int'(waveOut), lastWord);
    v = int'({{8{waveOut[23]}}, waveOut});
    chk(v - x <= 1 && x - v <= 1, {tag, " R7 settle"}, v, x);
    chk(waveOut[23:15] == '0 || waveOut[23:15] == '1, {tag, " R6 sign"}, int'(waveOut), lastWord);
  endtask

  initial begin
    doReset();
    testLoad();
    testIgnore();
    testBackToBack();
    testSettle(32'sh2852, "pos");
    testSettle(-32'sh2852, "neg");
    doReset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); nChecks++; nFails++; $display("FAIL watchdog"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule